// File: doc/BRIEF.md
# Speculative Load Alias Tracking Table

This block lets a pipeline hoist a load above stores that might write the same location. An early load registers its destination register number and its memory address in a small table. Every later store is compared against all tracked addresses at once, and any entry with a matching address is invalidated. When the consuming code reaches its verification point, it issues a check for the destination register. The table then answers whether the early value may still be used.

Checks come in two kinds. A reload-style check asks for the load to be repeated only when the speculation failed. A successful reload-style check also retires the entry. A redirect-style check asks the front end to branch to recovery code on failure, and it leaves the entry in place. A successful check adds no stall: the answer is registered and appears on the cycle after the check, for every check. The memory system and the recovery code are outside this block.

Top module: `altrk_table`

## Requirements
- R1: After reset no entry is valid, and `resp_valid` is low until a check is issued.
- R2: A check presented on cycle N produces exactly one of `resp_ok`, `resp_reload`, `resp_redirect` together with `resp_valid` on cycle N+1. Without a check on cycle N, all four outputs are low on cycle N+1.
- R3: A check of a register whose last early load has not been overtaken by an aliasing store reports success (`resp_ok`).
- R4: A store whose address equals an entry's address invalidates that entry. A store to any other address leaves the entry valid.
- R5: A single store invalidates every valid entry that holds its address, whichever registers those entries belong to.
- R6: A new early load to a register replaces that register's entry. The previous address is then no longer tracked, and only the new address is.
- R7: A check of a register that has never had an early load since reset reports failure.
- R8: A successful reload-style check (`chk_kind` = 0) clears the entry, so an identical second check fails.
- R9: A redirect-style check (`chk_kind` = 1) never changes the entry, so repeated successful redirect-style checks keep succeeding.
- R10: On failure, a reload-style check raises `resp_reload` and a redirect-style check raises `resp_redirect`.
- R11: When a store and an early load arrive on the same cycle, the store is applied first. The new entry survives even if its address equals the store's address.
- R12: A check sees the effect of a store presented on the same cycle, so an aliasing store alongside the check makes it fail.
- R13: A check is answered from the table contents before an early load presented on the same cycle. That load still installs its entry for later checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Early load presented this cycle |
| ld_reg | input | IDX_W | Destination register of the early load |
| ld_addr | input | ADDR_W | Memory address of the early load |
| st_valid | input | 1 | Store presented this cycle |
| st_addr | input | ADDR_W | Memory address of the store |
| chk_valid | input | 1 | Check presented this cycle |
| chk_reg | input | IDX_W | Register being checked |
| chk_kind | input | 1 | 0 = reload-style check, 1 = redirect-style check |
| resp_valid | output | 1 | Response present (one cycle after the check) |
| resp_ok | output | 1 | Speculated value may be used |
| resp_reload | output | 1 | Reload-style check failed: repeat the load |
| resp_redirect | output | 1 | Redirect-style check failed: branch to recovery |

## Verification
Table updates from loads, stores and reload-style checks take effect at the clock edge that samples them. A check response is registered once and is therefore due exactly one cycle after the check. The bench drives each stimulus on a falling edge and waits for one rising edge. It then samples the response on the following falling edge and compares it with a bench-side model of the table. Every stimulus cycle, including the ones without a check, is compared against that model. This is how a missing or a spurious response is caught on the cycle it appears.

// File: rtl/altrk_pkg.sv
package altrk_pkg;

  typedef enum logic {
    CHK_RELOAD   = 1'b0,
    CHK_REDIRECT = 1'b1
  } chk_kind_e;

  typedef struct packed {
    logic ok;
    logic reload;
    logic redirect;
  } chk_result_t;

endpackage

// File: rtl/altrk_entry.sv
module altrk_entry #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              snoop_en,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              clr_en,
  output logic              valid_o,
  output logic              live_o
);

  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic              snoop_hit;

  // Store snoop: matches only a currently valid entry.
  assign snoop_hit = snoop_en && valid_q && (addr_q == snoop_addr);
  // Entry state as seen after this cycle's store, before this cycle's load.
  assign live_o    = valid_q && !snoop_hit;
  assign valid_o   = valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (wr_en) begin
      valid_q <= 1'b1;
      addr_q  <= wr_addr;
    end else if (snoop_hit || clr_en) begin
      valid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/altrk_resp.sv
module altrk_resp
  import altrk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic chk_valid,
  input  logic chk_kind,
  input  logic chk_live,
  output logic resp_valid,
  output logic resp_ok,
  output logic resp_reload,
  output logic resp_redirect
);

  chk_kind_e   kind;
  chk_result_t res_d;

  assign kind = chk_kind_e'(chk_kind);

  always_comb begin
    res_d = '0;
    if (chk_valid) begin
      if (chk_live)                 res_d.ok       = 1'b1;
      else if (kind == CHK_RELOAD)  res_d.reload   = 1'b1;
      else                          res_d.redirect = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid    <= 1'b0;
      resp_ok       <= 1'b0;
      resp_reload   <= 1'b0;
      resp_redirect <= 1'b0;
    end else begin
      resp_valid    <= chk_valid;
      resp_ok       <= res_d.ok;
      resp_reload   <= res_d.reload;
      resp_redirect <= res_d.redirect;
    end
  end

endmodule

// File: rtl/altrk_table.sv
module altrk_table
  import altrk_pkg::*;
#(
  parameter  int NUM_REGS = 8,
  parameter  int ADDR_W   = 32,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [IDX_W-1:0]  ld_reg,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [IDX_W-1:0]  chk_reg,
  input  logic              chk_kind,
  output logic              resp_valid,
  output logic              resp_ok,
  output logic              resp_reload,
  output logic              resp_redirect
);

  logic [NUM_REGS-1:0] valid_vec;
  logic [NUM_REGS-1:0] live_vec;
  logic                chk_live;

  assign chk_live = live_vec[chk_reg];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    logic wr_sel;
    logic clr_sel;
    assign wr_sel  = ld_valid && (ld_reg == IDX_W'(i));
    assign clr_sel = chk_valid && (chk_reg == IDX_W'(i)) &&
                     (chk_kind_e'(chk_kind) == CHK_RELOAD) && live_vec[i];
    altrk_entry #(.ADDR_W(ADDR_W)) u_entry (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_sel),
      .wr_addr    (ld_addr),
      .snoop_en   (st_valid),
      .snoop_addr (st_addr),
      .clr_en     (clr_sel),
      .valid_o    (valid_vec[i]),
      .live_o     (live_vec[i])
    );
  end

  altrk_resp u_resp (
    .clk           (clk),
    .rst           (rst),
    .chk_valid     (chk_valid),
    .chk_kind      (chk_kind),
    .chk_live      (chk_live),
    .resp_valid    (resp_valid),
    .resp_ok       (resp_ok),
    .resp_reload   (resp_reload),
    .resp_redirect (resp_redirect)
  );

endmodule

// File: rtl/altrk_table_chk.sv
module altrk_table_chk #(
  parameter  int NUM_REGS = 8,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rst,
  input logic                ld_valid,
  input logic [IDX_W-1:0]    ld_reg,
  input logic                chk_valid,
  input logic [IDX_W-1:0]    chk_reg,
  input logic                chk_kind,
  input logic                resp_valid,
  input logic                resp_ok,
  input logic                resp_reload,
  input logic                resp_redirect,
  input logic [NUM_REGS-1:0] valid_vec
);

  // R2
  resp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $countones({resp_ok, resp_reload, resp_redirect}) == 1);

  // R2
  resp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !resp_valid |-> !(resp_ok || resp_reload || resp_redirect));

  // R2
  resp_due_chk: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> resp_valid);

  // R2
  resp_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !resp_valid);

  // R10
  reload_kind_chk: assert property (@(posedge clk) disable iff (rst)
    resp_reload |-> $past(chk_kind) == 1'b0);

  // R10
  redirect_kind_chk: assert property (@(posedge clk) disable iff (rst)
    resp_redirect |-> $past(chk_kind) == 1'b1);

  // R7
  empty_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && !valid_vec[chk_reg]) |=> !resp_ok);

  // R11
  load_installs_chk: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> valid_vec[$past(ld_reg)]);

  // R8
  reload_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && !chk_kind && !(ld_valid && ld_reg == chk_reg))
      |=> (resp_ok |-> !valid_vec[$past(chk_reg)]));

endmodule

bind altrk_table altrk_table_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ld_valid      (ld_valid),
  .ld_reg        (ld_reg),
  .chk_valid     (chk_valid),
  .chk_reg       (chk_reg),
  .chk_kind      (chk_kind),
  .resp_valid    (resp_valid),
  .resp_ok       (resp_ok),
  .resp_reload   (resp_reload),
  .resp_redirect (resp_redirect),
  .valid_vec     (valid_vec)
);

// File: tb/altrk_table_test.sv
module altrk_table_test;

  localparam int NUM_REGS = 8;
  localparam int ADDR_W   = 32;
  localparam int IDX_W    = $clog2(NUM_REGS);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ld_valid = 1'b0;
  logic [IDX_W-1:0]  ld_reg = '0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic              st_valid = 1'b0;
  logic [ADDR_W-1:0] st_addr = '0;
  logic              chk_valid = 1'b0;
  logic [IDX_W-1:0]  chk_reg = '0;
  logic              chk_kind = 1'b0;
  logic              resp_valid, resp_ok, resp_reload, resp_redirect;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // bench-side table model
  bit          m_valid [NUM_REGS];
  logic [31:0] m_addr  [NUM_REGS];

  always #10 clk = ~clk;

  altrk_table #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_addr(ld_addr),
    .st_valid(st_valid), .st_addr(st_addr),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_kind(chk_kind),
    .resp_valid(resp_valid), .resp_ok(resp_ok),
    .resp_reload(resp_reload), .resp_redirect(resp_redirect)
  );

  // response code: 0 none, 1 ok, 2 reload, 3 redirect, 7 malformed
  function automatic int resp_code();
    int c;
    c = 7;
    if (!resp_valid && !resp_ok && !resp_reload && !resp_redirect) c = 0;
    else if (resp_valid && resp_ok && !resp_reload && !resp_redirect) c = 1;
    else if (resp_valid && !resp_ok && resp_reload && !resp_redirect) c = 2;
    else if (resp_valid && !resp_ok && !resp_reload && resp_redirect) c = 3;
    return c;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: response code %0d, expected %0d", tag, act, exp);
    end
  endtask

  // One stimulus cycle; the model predicts the registered response.
  task automatic step(input string tag,
                      input bit ldv, input int ldr, input int lda,
                      input bit stv, input int sta,
                      input bit ckv, input int ckr, input bit ckk);
    int  exp;
    bit  live;
    ld_valid  = ldv; ld_reg  = IDX_W'(ldr); ld_addr = ADDR_W'(lda);
    st_valid  = stv; st_addr = ADDR_W'(sta);
    chk_valid = ckv; chk_reg = IDX_W'(ckr); chk_kind = ckk;
    // model: store first, then check, then load
    live = m_valid[ckr] && !(stv && m_addr[ckr] == 32'(sta));
    exp  = !ckv ? 0 : (live ? 1 : (ckk ? 3 : 2));
    for (int i = 0; i < NUM_REGS; i++)
      if (stv && m_valid[i] && m_addr[i] == 32'(sta)) m_valid[i] = 0;
    if (ckv && !ckk && live) m_valid[ckr] = 0;
    if (ldv) begin m_valid[ldr] = 1; m_addr[ldr] = 32'(lda); end
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0;
    check(tag, resp_code(), exp);
  endtask

  task automatic sweep(input string tag);
    for (int r = 0; r < NUM_REGS; r++) step(tag, 0, 0, 0, 0, 0, 1, r, 1);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < NUM_REGS; i++) begin m_valid[i] = 0; m_addr[i] = 0; end
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 idle after reset", resp_code(), 0);
    sweep("R1 R7 empty table");
    step("R2 no check, no response", 0, 0, 0, 0, 0, 0, 0, 0);

    // R3, R9
    step("R3 load", 1, 2, 'h40, 0, 0, 0, 0, 0);
    step("R3 redirect check ok", 0, 0, 0, 0, 0, 1, 2, 1);
    step("R9 redirect check repeats", 0, 0, 0, 0, 0, 1, 2, 1);
    // R8, R10
    step("R8 reload check ok", 0, 0, 0, 0, 0, 1, 2, 0);
    step("R8 R10 second reload check fails", 0, 0, 0, 0, 0, 1, 2, 0);
    // R4
    step("R4 load", 1, 3, 'h80, 0, 0, 0, 0, 0);
    step("R4 store other address", 0, 0, 0, 1, 'h84, 0, 0, 0);
    step("R4 entry kept", 0, 0, 0, 0, 0, 1, 3, 1);
    step("R4 aliasing store", 0, 0, 0, 1, 'h80, 0, 0, 0);
    step("R4 R10 entry gone", 0, 0, 0, 0, 0, 1, 3, 0);
    // R5
    step("R5 load a", 1, 0, 'h100, 0, 0, 0, 0, 0);
    step("R5 load b", 1, 1, 'h100, 0, 0, 0, 0, 0);
    step("R5 load c", 1, 5, 'h100, 0, 0, 0, 0, 0);
    step("R5 store", 0, 0, 0, 1, 'h100, 0, 0, 0);
    sweep("R5 all matches cleared");
    // R6
    step("R6 load old", 1, 4, 'h10, 0, 0, 0, 0, 0);
    step("R6 load new", 1, 4, 'h20, 0, 0, 0, 0, 0);
    step("R6 store old address", 0, 0, 0, 1, 'h10, 0, 0, 0);
    step("R6 new entry kept", 0, 0, 0, 0, 0, 1, 4, 1);
    step("R6 store new address", 0, 0, 0, 1, 'h20, 0, 0, 0);
    step("R6 new entry gone", 0, 0, 0, 0, 0, 1, 4, 1);
    // R11
    step("R11 store and load same cycle", 1, 6, 'h30, 1, 'h30, 0, 0, 0);
    step("R11 load survives", 0, 0, 0, 0, 0, 1, 6, 1);
    // R12
    step("R12 load", 1, 7, 'h50, 0, 0, 0, 0, 0);
    step("R12 store with check", 0, 0, 0, 1, 'h50, 1, 7, 1);
    // R13
    step("R13 load with check", 1, 1, 'h60, 0, 0, 1, 1, 0);
    step("R13 load installed", 0, 0, 0, 0, 0, 1, 1, 1);
    sweep("R13 table snapshot");

    // mixed sweep over a small address set, model-predicted
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R4 R5 R8 R9 mixed", lfsr[0], int'(lfsr[3:1]), int'(lfsr[5:4]) * 8,
           lfsr[6], int'(lfsr[8:7]) * 8,
           lfsr[9] | lfsr[10], int'(lfsr[13:11]), lfsr[14]);
    end
    sweep("R9 final snapshot");

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule